// File: doc/BRIEF.md
# Serial Receive Path with Receive Queue and Line Status

This block is the receive half of an asynchronous serial port. It samples a serial input, assembles characters of one start bit, eight data bits sent least significant bit first, an optional parity bit and a stop bit, and stores each character in a receive queue. Every queue entry also carries the character's own framing and parity error tags. A line status word reports data ready, overrun, parity error and framing error. The parity and framing flags always describe the character at the head of the queue, not the most recently received one.

The host takes characters through a valid/ready stream port. `rd_valid` stays high while at least one character is queued. A character leaves on a clock edge where both `rd_valid` and `rd_ready` are high. Until then `rd_data` holds that character. The serial side cannot be held back, so a character that finds no room is an overrun. In queue mode the stored characters are kept and the new one is lost. In single-register mode the new one replaces the unread one. The host pulses `lsr_rd` for each read of the line status word. The interrupt output combines the error flags with a data-available condition that uses a selectable fill threshold. The bit period, in clock cycles, is a fixed parameter.

Top module: `uart_rx_lsr`

## Requirements
- R1: The line idles high. A low level held for half a bit period starts a frame. Eight data bits follow, least significant first, each sampled at mid-bit. Characters leave `rd_data` in the order they were received.
- R2: `par_mode` selects the parity check: 2'b01 even, 2'b10 odd, 2'b00 or 2'b11 none. With even parity, the data bits plus the parity bit must hold an even number of ones. With odd parity, they must hold an odd number. A mismatch tags the character with a parity error. With none selected, no parity bit is expected and no character is ever tagged.
- R3: Only the first stop bit is checked. A 0 sampled there tags the character with a framing error. That low sample is then taken as the middle of the next start bit, so the next data bits are sampled one, two, and more bit periods later, with no further start bit needed.
- R4: `line_status` bit 0 is data ready (queue not empty), bit 1 is overrun, bit 2 is parity error and bit 3 is framing error. Bits 2 and 3 are loaded from the tags of each character that becomes the head of the queue.
- R5: An `lsr_rd` pulse clears bits 2 and 3. If a new character becomes the head in the same cycle, its tags are loaded instead.
- R6: With `fifo_en` high, the queue holds 16 characters. A character that completes while 16 are stored, and none leaves in that cycle, is discarded. The stored characters are unchanged, and the overrun flag sets whatever `trig_sel` is.
- R7: With `fifo_en` low, the queue acts as one holding register. A character that completes while an unread one is present overwrites it, sets the overrun flag, and loads its own tags into bits 2 and 3.
- R8: The overrun flag clears only on an `lsr_rd` pulse. If an overrun occurs in the same cycle as the pulse, the flag stays set.
- R9: A `fifo_clr` pulse empties the queue on the next edge. It discards any character completing in that cycle and leaves all three error flags unchanged.
- R10: `irq` is high while any error flag is set, or while data is available. In queue mode, data is available when the fill count is at least the `trig_sel` threshold: 1, 4, 8 or 14 for codes 0 to 3. In single-register mode, one character is enough. `irq` rises in the same cycle the overrun flag sets.
- R11: `rd_valid` is high exactly when the queue is not empty. In queue mode, while `rd_valid` is high and `rd_ready` is low, `rd_data` does not change.
- R12: After reset the queue is empty, all flags are clear and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial data input, idle high |
| par_mode | input | 2 | Parity check select |
| fifo_en | input | 1 | 1 selects the 16-entry queue, 0 selects the single holding register |
| fifo_clr | input | 1 | One-cycle pulse that empties the queue |
| trig_sel | input | 2 | Data-available threshold select |
| rd_valid | output | 1 | A character is available |
| rd_ready | input | 1 | Host accepts the character on this edge |
| rd_data | output | 8 | Head character |
| lsr_rd | input | 1 | One-cycle pulse marking a line status read |
| line_status | output | 4 | {framing, parity, overrun, data ready} |
| irq | output | 1 | Receive interrupt |

## Verification
Two pairs of events can land on the same clock edge, and the bench forces both. A line status read can coincide with a new character reaching the head of the queue. The bench does this by pulsing `lsr_rd` together with `rd_ready` while an error-tagged character waits second in the queue, and expects the new tags to survive the read. An overrun or a queue clear can coincide with a character completing. The bench computes the exact edge on which each character arrives from its bit timing, and pulses `lsr_rd` or `fifo_clr` on that edge. It then expects the overrun flag to survive the read, and the cleared queue to stay empty. A behavioural model in the bench predicts every output on every cycle, so any tie-break decided the wrong way shows up as a mismatch.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned CHAR_W = 8;

  // status word bit positions
  localparam int unsigned ST_DR = 0;
  localparam int unsigned ST_OE = 1;
  localparam int unsigned ST_PE = 2;
  localparam int unsigned ST_FE = 3;
  localparam int unsigned ST_W  = 4;

  typedef enum logic [1:0] {
    PAR_OFF  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF2 = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic              fe;
    logic              pe;
    logic [CHAR_W-1:0] data;
  } rx_ent_t;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int unsigned CPB = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_i,
  input  par_mode_e par_mode,
  output logic      out_vld,
  output rx_ent_t   out_ent
);
  localparam int unsigned CW   = (CPB > 2) ? $clog2(CPB) : 2;
  localparam int unsigned HALF = CPB / 2 - 1;
  localparam int unsigned BW   = $clog2(CHAR_W);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_e;

  st_e               st;
  logic [1:0]        sync_q;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bit_idx;
  logic [CHAR_W-1:0] shreg;
  logic              par_bit;
  logic              rx_s;
  logic              par_on;
  logic              par_bad;

  assign rx_s   = sync_q[1];
  assign par_on = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);

  always_comb begin
    case (par_mode)
      PAR_EVEN: par_bad = (^shreg) ^ par_bit;
      PAR_ODD:  par_bad = ~((^shreg) ^ par_bit);
      default:  par_bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      st      <= S_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      out_vld <= 1'b0;
      out_ent <= '0;
    end else begin
      sync_q  <= {sync_q[0], rx_i};
      out_vld <= 1'b0;
      case (st)
        S_IDLE: begin
          if (!rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
        end
        S_START: begin
          if (cnt == CW'(HALF)) begin
            cnt     <= '0;
            bit_idx <= '0;
            st      <= rx_s ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt == CW'(CPB - 1)) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[CHAR_W-1:1]};
            if (bit_idx == BW'(CHAR_W - 1)) st <= par_on ? S_PAR : S_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: begin
          if (cnt == CW'(CPB - 1)) begin
            cnt     <= '0;
            par_bit <= rx_s;
            st      <= S_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (cnt == CW'(CPB - 1)) begin
            cnt          <= '0;
            out_vld      <= 1'b1;
            out_ent.data <= shreg;
            out_ent.fe   <= ~rx_s;
            out_ent.pe   <= par_bad;
            bit_idx      <= '0;
            // a low stop sample doubles as the centre of the next start bit
            st           <= rx_s ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CNTW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fifo_en,
  input  logic              push,
  input  rx_ent_t           push_ent,
  input  logic              pop,
  output logic [CHAR_W-1:0] head_data,
  output rx_ent_t           nxt_head,
  output logic [CNTW-1:0]   fill,
  output logic              head_load,
  output logic              ovf
);
  rx_ent_t         mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr, rd_nxt;
  logic [CNTW-1:0] after_pop, limit;
  logic            pop_ok, room, do_wr, do_ovw;

  assign pop_ok    = pop && (fill != '0);
  assign after_pop = fill - CNTW'(pop_ok);
  assign limit     = fifo_en ? CNTW'(DEPTH) : CNTW'(1);
  assign room      = after_pop < limit;
  assign do_wr     = push && room && !clr;
  assign do_ovw    = push && !room && !fifo_en && !clr;
  assign ovf       = push && !room && !clr;
  assign rd_nxt    = rd_ptr + AW'(pop_ok);
  assign head_load = !clr && (do_ovw || (pop_ok && after_pop != '0) ||
                              (after_pop == '0 && do_wr));
  assign nxt_head  = (do_ovw || after_pop == '0) ? push_ent : mem[rd_nxt];
  assign head_data = mem[rd_ptr].data;

  always_ff @(posedge clk) begin
    if (do_wr)  mem[wr_ptr] <= push_ent;
    if (do_ovw) mem[rd_nxt] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(do_wr);
      rd_ptr <= rd_nxt;
      fill   <= after_pop + CNTW'(do_wr);
    end
  end
endmodule

// File: rtl/rx_status.sv
module rx_status #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNTW = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            head_load,
  input  logic            nxt_fe,
  input  logic            nxt_pe,
  input  logic            ovf,
  input  logic            lsr_rd,
  input  logic [CNTW-1:0] fill,
  input  logic            fifo_en,
  input  logic [1:0]      trig_sel,
  output logic            fe,
  output logic            pe,
  output logic            oe,
  output logic            irq
);
  logic [CNTW-1:0] thr;
  logic            avail;

  always_comb begin
    case (trig_sel)
      2'd0:    thr = CNTW'(1);
      2'd1:    thr = CNTW'(DEPTH / 4);
      2'd2:    thr = CNTW'(DEPTH / 2);
      default: thr = CNTW'(DEPTH - 2);
    endcase
  end

  assign avail = fifo_en ? (fill >= thr) : (fill != '0);
  assign irq   = oe | pe | fe | avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe <= 1'b0;
      pe <= 1'b0;
      oe <= 1'b0;
    end else begin
      if (head_load) begin
        fe <= nxt_fe;
        pe <= nxt_pe;
      end else if (lsr_rd) begin
        fe <= 1'b0;
        pe <= 1'b0;
      end
      if (ovf)         oe <= 1'b1;
      else if (lsr_rd) oe <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned FIFO_DEPTH   = 16,
  localparam int unsigned CNTW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic [1:0]        par_mode,
  input  logic              fifo_en,
  input  logic              fifo_clr,
  input  logic [1:0]        trig_sel,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [CHAR_W-1:0] rd_data,
  input  logic              lsr_rd,
  output logic [ST_W-1:0]   line_status,
  output logic              irq
);
  logic            char_vld;
  rx_ent_t         char_ent;
  rx_ent_t         nxt_head;
  logic [CNTW-1:0] fill;
  logic            head_load, ovf, pop;
  logic            fe, pe, oe;

  assign rd_valid = (fill != '0);
  assign pop      = rd_valid && rd_ready;

  uart_rx_deser #(.CPB(CLKS_PER_BIT)) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_i     (rx_i),
    .par_mode (par_mode_e'(par_mode)),
    .out_vld  (char_vld),
    .out_ent  (char_ent)
  );

  rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_clr),
    .fifo_en   (fifo_en),
    .push      (char_vld),
    .push_ent  (char_ent),
    .pop       (pop),
    .head_data (rd_data),
    .nxt_head  (nxt_head),
    .fill      (fill),
    .head_load (head_load),
    .ovf       (ovf)
  );

  rx_status #(.DEPTH(FIFO_DEPTH)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .head_load (head_load),
    .nxt_fe    (nxt_head.fe),
    .nxt_pe    (nxt_head.pe),
    .ovf       (ovf),
    .lsr_rd    (lsr_rd),
    .fill      (fill),
    .fifo_en   (fifo_en),
    .trig_sel  (trig_sel),
    .fe        (fe),
    .pe        (pe),
    .oe        (oe),
    .irq       (irq)
  );

  always_comb begin
    line_status        = '0;
    line_status[ST_DR] = rd_valid;
    line_status[ST_OE] = oe;
    line_status[ST_PE] = pe;
    line_status[ST_FE] = fe;
  end
endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNTW = $clog2(DEPTH) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lsr_rd,
  input logic [3:0]      line_status,
  input logic            head_load,
  input logic            fifo_en,
  input logic            fifo_clr,
  input logic            char_vld,
  input logic            char_pe,
  input logic [CNTW-1:0] fill,
  input logic            pop,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [7:0]      rd_data,
  input logic [1:0]      par_mode
);
  AST_OE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    line_status[1] && !lsr_rd |=> line_status[1]); // R8

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !head_load |=> !line_status[3] && !line_status[2]); // R5

  AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && char_vld && (int'(fill) == DEPTH) && !pop && !fifo_clr
    |=> (int'(fill) == DEPTH) && line_status[1]); // R6

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && rd_valid && !rd_ready && !fifo_clr |=> rd_valid && $stable(rd_data)); // R11

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> !rd_valid); // R9

  AST_NO_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    char_vld && (par_mode == 2'b00 || par_mode == 2'b11) |-> !char_pe); // R2

  always @(posedge clk) begin
    if (rst_n) begin
      AST_FILL_CAP: assert (int'(fill) <= DEPTH); // R6
    end
  end
endmodule

bind uart_rx_lsr uart_rx_lsr_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lsr_rd      (lsr_rd),
  .line_status (line_status),
  .head_load   (head_load),
  .fifo_en     (fifo_en),
  .fifo_clr    (fifo_clr),
  .char_vld    (char_vld),
  .char_pe     (char_ent.pe),
  .fill        (fill),
  .pop         (pop),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_data     (rd_data),
  .par_mode    (par_mode)
);

// File: tb/uart_rx_lsr_test.sv
module uart_rx_lsr_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 8;
  localparam int DEPTH      = 16;
  localparam int HALFB      = CPB / 2 - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_i = 1'b1;
  logic [1:0] par_mode = 2'b00;
  logic       fifo_en = 1'b1;
  logic       fifo_clr = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic       rd_ready = 1'b0;
  logic       lsr_rd = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [3:0] line_status;
  logic       irq;

  uart_rx_lsr #(.CLKS_PER_BIT(CPB), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .par_mode(par_mode),
    .fifo_en(fifo_en), .fifo_clr(fifo_clr), .trig_sel(trig_sel),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .lsr_rd(lsr_rd), .line_status(line_status), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct { int at; logic [7:0] d; bit fe; bit pe; } arr_t;
  typedef struct { logic [7:0] d; bit fe; bit pe; } ent_t;

  arr_t arrivals[$];
  ent_t mq[$];
  bit   m_oe, m_fe, m_pe;
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  function automatic int thr(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return DEPTH / 4;
      2'd2: return DEPTH / 2;
      default: return DEPTH - 2;
    endcase
  endfunction

  function automatic int frame_len(input bit no_start);
    int pon;
    pon = (par_mode == 2'b01 || par_mode == 2'b10) ? 1 : 0;
    return (no_start ? cyc + 1 - CPB : cyc + 1) + 4 + HALFB + (9 + pon) * CPB;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // reference model: updates on every edge from the inputs the bench drives
  always @(posedge clk) begin
    bit   psh, popd, hl, ovf;
    ent_t ne;
    int   lim;
    cyc++;
    if (!rst_n) begin
      mq.delete();
      m_oe = 0; m_fe = 0; m_pe = 0;
    end else begin
      psh = 0; popd = 0; hl = 0; ovf = 0;
      ne.d = 8'h00; ne.fe = 0; ne.pe = 0;
      if (arrivals.size() > 0 && arrivals[0].at == cyc) begin
        psh = 1;
        ne.d = arrivals[0].d; ne.fe = arrivals[0].fe; ne.pe = arrivals[0].pe;
        void'(arrivals.pop_front());
      end
      lim = fifo_en ? DEPTH : 1;
      if (fifo_clr) begin
        mq.delete();
      end else begin
        if (rd_ready && mq.size() > 0) begin
          void'(mq.pop_front());
          popd = 1;
        end
        if (popd && mq.size() > 0) hl = 1;
        if (psh) begin
          if (mq.size() < lim) begin
            mq.push_back(ne);
            if (mq.size() == 1) hl = 1;
          end else begin
            ovf = 1;
            if (!fifo_en) begin
              mq[0] = ne;
              hl = 1;
            end
          end
        end
      end
      if (hl) begin
        m_fe = mq[0].fe; m_pe = mq[0].pe;
      end else if (lsr_rd) begin
        m_fe = 0; m_pe = 0;
      end
      if (ovf) m_oe = 1;
      else if (lsr_rd) m_oe = 0;
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      int  cnt;
      bit  avail;
      cnt = mq.size();
      avail = fifo_en ? (cnt >= thr(trig_sel)) : (cnt != 0);
      chk("R11", rd_valid, cnt != 0, "rd_valid");
      if (cnt != 0) chk("R1", rd_data, mq[0].d, "rd_data");
      chk("R6", line_status[1], m_oe, "overrun flag");
      chk("R4", line_status[2], m_pe, "parity flag");
      chk("R3", line_status[3], m_fe, "framing flag");
      chk("R10", irq, m_oe | m_pe | m_fe | avail, "irq");
    end
  end

  task automatic send(input logic [7:0] d, input bit bad_par, input bit stop, input bit no_start);
    bit   pon;
    logic pb;
    arr_t a;
    pon = (par_mode == 2'b01 || par_mode == 2'b10);
    pb  = (par_mode == 2'b10) ? ~^d : ^d;
    if (bad_par) pb = ~pb;
    a.at = frame_len(no_start); a.d = d; a.fe = !stop; a.pe = pon && bad_par;
    arrivals.push_back(a);
    if (!no_start) begin
      rx_i = 1'b0; repeat (CPB) @(negedge clk);
    end
    for (int i = 0; i < 8; i++) begin
      rx_i = d[i]; repeat (CPB) @(negedge clk);
    end
    if (pon) begin
      rx_i = pb; repeat (CPB) @(negedge clk);
    end
    rx_i = stop; repeat (CPB) @(negedge clk);
    if (stop) rx_i = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_lsr();
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
  endtask

  task automatic pop_one();
    rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic settle_chk(input string tag, input int act, input int exp, input string what);
    #1; chk(tag, act, exp, what);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int tgt;
    repeat (3) @(negedge clk);
    settle_chk("R12", {irq, line_status, rd_valid}, 0, "reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    settle_chk("R12", {irq, line_status}, 0, "outputs after reset release");

    // R1: plain frames in order, no parity
    send(8'hA5, 0, 1, 0); send(8'h3C, 0, 1, 0); send(8'h01, 0, 1, 0);
    idle(6);
    settle_chk("R1", rd_data, 8'hA5, "first character at head");
    repeat (3) pop_one();
    idle(2);

    // R2: even then odd parity, good and corrupted
    par_mode = 2'b01;
    send(8'h5A, 0, 1, 0); idle(6);
    settle_chk("R2", line_status[2], 0, "even parity correct");
    pop_one();
    send(8'h5B, 1, 1, 0); idle(6);
    settle_chk("R2", line_status[2], 1, "even parity corrupted");
    pop_one(); pulse_lsr();
    par_mode = 2'b10;
    send(8'h77, 1, 1, 0); idle(6);
    settle_chk("R2", line_status[2], 1, "odd parity corrupted");
    pop_one(); pulse_lsr();
    send(8'h76, 0, 1, 0); idle(6);
    settle_chk("R2", line_status[2], 0, "odd parity correct");
    pop_one();
    par_mode = 2'b00;
    send(8'hC3, 1, 1, 0); idle(6);
    settle_chk("R2", line_status[2], 0, "parity off never tags");
    pop_one(); idle(2);

    // R3: bad stop bit, low sample becomes the next start
    send(8'h96, 0, 0, 0); send(8'h2D, 0, 1, 1); idle(6);
    settle_chk("R3", line_status[3], 1, "framing flag on head");
    pop_one();
    settle_chk("R3", rd_data, 8'h2D, "resynchronised character");
    settle_chk("R4", line_status[3], 0, "flag follows new head");
    pop_one(); idle(2);

    // R5: status read in the same cycle a tagged character reaches the head
    par_mode = 2'b01;
    send(8'h10, 0, 1, 0); send(8'h11, 1, 1, 0); idle(6);
    settle_chk("R4", line_status[2], 0, "tag waits behind head");
    rd_ready = 1'b1; lsr_rd = 1'b1; @(negedge clk); rd_ready = 1'b0; lsr_rd = 1'b0;
    settle_chk("R5", line_status[2], 1, "head tags win over read");
    pulse_lsr();
    settle_chk("R5", line_status[2], 0, "read clears parity flag");
    pop_one(); par_mode = 2'b00; idle(2);

    // R6 / R10: fill the queue with threshold 8, then one more
    trig_sel = 2'd2;
    for (int i = 0; i < DEPTH; i++) send(8'(8'h40 + i), 0, 1, 0);
    idle(6);
    settle_chk("R10", irq, 1, "threshold reached");
    trig_sel = 2'd3;
    tgt = frame_len(0);
    fork
      send(8'hEE, 0, 1, 0);
      begin
        while (cyc + 1 != tgt) @(negedge clk);
        lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
      end
    join
    idle(4);
    settle_chk("R8", line_status[1], 1, "overrun beats same-cycle read");
    settle_chk("R6", rd_data, 8'h40, "queue head kept");

    // R9: clear collides with an arriving character; flags kept
    tgt = frame_len(0);
    fork
      send(8'hDD, 0, 1, 0);
      begin
        while (cyc + 1 != tgt) @(negedge clk);
        fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
      end
    join
    idle(4);
    settle_chk("R9", rd_valid, 0, "queue empty after clear");
    settle_chk("R9", line_status[1], 1, "overrun kept through clear");
    pulse_lsr();
    settle_chk("R8", line_status[1], 0, "read clears overrun");

    // R7: single holding register overwrite
    fifo_en = 1'b0; par_mode = 2'b01;
    send(8'h11, 0, 1, 0); send(8'h22, 1, 1, 0); idle(6);
    settle_chk("R7", rd_data, 8'h22, "newer character replaces unread one");
    settle_chk("R7", line_status[1], 1, "overwrite flags overrun");
    settle_chk("R7", line_status[2], 1, "overwriting tags loaded");
    pop_one(); pulse_lsr();
    par_mode = 2'b00; fifo_en = 1'b1; trig_sel = 2'd1;
    for (int i = 0; i < 4; i++) send(8'(8'h80 + i), 0, 1, 0);
    idle(6);
    settle_chk("R10", irq, 1, "threshold four");
    pop_one(); idle(1);
    settle_chk("R10", irq, 0, "below threshold four");
    repeat (3) pop_one();
    idle(4);
    finish_run();
  end
endmodule